// File: doc/BRIEF.md
# FIFO DMA Request Generator

This block sits between a serial shifter and a DMA engine. It holds a transmit FIFO, which software or the DMA engine fills and the shifter drains, and a receive FIFO, which the shifter fills and software or the DMA engine drains. Both FIFOs are 16 bits wide and 8 entries deep. From the fill levels it raises two kinds of DMA request per direction. The single request asks for one transfer. The burst request asks for a group of four.

Each direction has its own enable bit. A small write-only register port sets the enable bits and the interrupt mask, and clears status bits by writing ones. The DMA engine signals the end of a transfer with a one-cycle done pulse per channel. A done pulse sets a sticky status bit. The interrupt output is raised when any status bit is set and its mask bit is also set. A write to a full transmit FIFO and a read from an empty receive FIFO are both dropped, and each sets its own error status bit.

Each channel's request logic is a small state machine with three states:
- `REQ_IDLE`: no request.
- `REQ_SINGLE`: single request only.
- `REQ_BURST`: single and burst requests.

The machine moves to `REQ_IDLE` when the channel is disabled or its level is zero. It moves to `REQ_BURST` when the level is at least four. Otherwise it moves to `REQ_SINGLE`. Any state can reach any other in one step. The next state is computed from the next fill count and the next enable value, so the requests follow the registered count and the registered enable.

Top module: `dmareq_gen`

## Requirements
- R1: After reset:
  - all four request outputs, `irq` and `irq_status` are 0;
  - `tx_empty` is 1 and `rx_full` is 0;
  - enables and mask are 0.
- R2: `rx_req_single` is 1 exactly when RX is enabled and the receive FIFO holds at least one entry.
- R3: `rx_req_burst` is 1 exactly when RX is enabled and the receive FIFO holds four or more entries.
- R4: `tx_req_single` is 1 exactly when TX is enabled and the transmit FIFO has at least one free slot.
- R5: `tx_req_burst` is 1 exactly when TX is enabled and the transmit FIFO has four or more free slots.
- R6: Register writes use `reg_addr`:
  - address 0 sets the enables, with `reg_wdata[0]` for RX and `reg_wdata[1]` for TX;
  - address 1 loads the 4-bit mask;
  - address 2 clears the status bits written as one;
  - address 3 has no effect.
  
  Requests change in the cycle after a push, pop or enable write.
- R7: Each FIFO returns its data in write order, holds at most 8 entries, and drops a push when full. `tx_pop_data` and `rx_rd_data` show the oldest entry.
- R8: The status bits are sticky:
  - a pulse on `dma_rx_done` sets `irq_status[0]`;
  - a pulse on `dma_tx_done` sets `irq_status[1]`;
  - a write of one to address 2 clears a bit;
  - when a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: `irq` equals the OR over the four bits of `irq_status & mask`. It follows a status or mask change by one cycle.
- R10: Two accesses are dropped and flag an error:
  - a write to a full transmit FIFO leaves the FIFO unchanged and sets `irq_status[2]`;
  - a read from an empty receive FIFO leaves the FIFO unchanged and sets `irq_status[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 enable, 1 mask, 2 clear) |
| reg_wdata | input | 4 | Register write data |
| tx_wr_en | input | 1 | Write into transmit FIFO |
| tx_wr_data | input | 16 | Transmit write data |
| tx_pop | input | 1 | Shifter takes the transmit head |
| tx_pop_data | output | 16 | Transmit FIFO head |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_push | input | 1 | Shifter pushes a received word |
| rx_push_data | input | 16 | Received word |
| rx_full | output | 1 | Receive FIFO full |
| rx_rd_en | input | 1 | Read from receive FIFO |
| rx_rd_data | output | 16 | Receive FIFO head |
| dma_rx_done | input | 1 | RX transfer complete pulse |
| dma_tx_done | input | 1 | TX transfer complete pulse |
| rx_req_single | output | 1 | RX single request |
| rx_req_burst | output | 1 | RX burst request |
| tx_req_single | output | 1 | TX single request |
| tx_req_burst | output | 1 | TX burst request |
| irq_status | output | 4 | Raw status {rx_unf, tx_ovf, tx_done, rx_done} |
| irq | output | 1 | Masked interrupt |

## Verification
Every result of this block is due one clock edge after the stimulus:
- pushes, pops and enable writes appear on the requests;
- done pulses, clears and error accesses appear on `irq_status`;
- mask writes appear on `irq`.

The bench drives each stimulus for exactly one cycle starting at a falling edge and samples at the following falling edge, so exactly one rising edge separates the two. FIFO head data is sampled at the falling edge before its pop, while it is still at the head. The fill sweeps run each FIFO through every level from 0 to 8 and one access past the limit, and compare both requests against levels computed in the bench.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
    typedef enum logic [1:0] {
        REQ_IDLE   = 2'd0,
        REQ_SINGLE = 2'd1,
        REQ_BURST  = 2'd2
    } req_state_e;

    localparam logic [1:0] ADDR_ENABLE = 2'd0;
    localparam logic [1:0] ADDR_MASK   = 2'd1;
    localparam logic [1:0] ADDR_CLEAR  = 2'd2;

    localparam int unsigned ST_W       = 4;
    localparam int unsigned ST_RX_DONE = 0;
    localparam int unsigned ST_TX_DONE = 1;
    localparam int unsigned ST_TX_OVF  = 2;
    localparam int unsigned ST_RX_UNF  = 3;
endpackage

// File: rtl/dmareq_fifo.sv
module dmareq_fifo #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count_nxt
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ok, pop_ok;

    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        count_nxt = count;
        if (push_ok && !pop_ok) count_nxt = count + CNT_W'(1);
        if (pop_ok && !push_ok) count_nxt = count - CNT_W'(1);
    end

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            full   <= 1'b0;
            empty  <= 1'b1;
        end else begin
            if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
            count <= count_nxt;
            full  <= (count_nxt == CNT_W'(DEPTH));
            empty <= (count_nxt == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    assign head_data = mem[rd_ptr];
endmodule

// File: rtl/dmareq_req_fsm.sv
module dmareq_req_fsm
    import dmareq_pkg::*;
#(
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned THRESH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_nxt,
    input  logic [CNT_W-1:0] level_nxt,
    output logic             req_single,
    output logic             req_burst
);
    req_state_e state_q, state_d;

    always_comb begin
        if (!en_nxt || level_nxt == '0)
            state_d = REQ_IDLE;
        else if (level_nxt >= CNT_W'(THRESH))
            state_d = REQ_BURST;
        else
            state_d = REQ_SINGLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_single = 1'b0;
        req_burst  = 1'b0;
        unique case (state_q)
            REQ_IDLE:   ;
            REQ_SINGLE: req_single = 1'b1;
            REQ_BURST: begin
                req_single = 1'b1;
                req_burst  = 1'b1;
            end
            default:    ;
        endcase
    end
endmodule

// File: rtl/dmareq_ctl_regs.sv
module dmareq_ctl_regs
    import dmareq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [ST_W-1:0] reg_wdata,
    input  logic [ST_W-1:0] set_vec,
    output logic            rx_en_nxt,
    output logic            tx_en_nxt,
    output logic [ST_W-1:0] status,
    output logic            irq
);
    logic [ST_W-1:0] mask_q, clr_vec;
    logic            rx_en_q, tx_en_q, en_wr;

    assign en_wr     = reg_we && (reg_addr == ADDR_ENABLE);
    assign rx_en_nxt = en_wr ? reg_wdata[0] : rx_en_q;
    assign tx_en_nxt = en_wr ? reg_wdata[1] : tx_en_q;
    assign clr_vec   = (reg_we && reg_addr == ADDR_CLEAR) ? reg_wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_q <= 1'b0;
            tx_en_q <= 1'b0;
            mask_q  <= '0;
            status  <= '0;
        end else begin
            rx_en_q <= rx_en_nxt;
            tx_en_q <= tx_en_nxt;
            if (reg_we && reg_addr == ADDR_MASK) mask_q <= reg_wdata;
            status <= (status & ~clr_vec) | set_vec;
        end
    end

    assign irq = |(status & mask_q);
endmodule

// File: rtl/dmareq_gen.sv
module dmareq_gen
    import dmareq_pkg::*;
#(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned THRESH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [3:0]       reg_wdata,
    input  logic             tx_wr_en,
    input  logic [WIDTH-1:0] tx_wr_data,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_pop_data,
    output logic             tx_empty,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_push_data,
    output logic             rx_full,
    input  logic             rx_rd_en,
    output logic [WIDTH-1:0] rx_rd_data,
    input  logic             dma_rx_done,
    input  logic             dma_tx_done,
    output logic             rx_req_single,
    output logic             rx_req_burst,
    output logic             tx_req_single,
    output logic             tx_req_burst,
    output logic [3:0]       irq_status,
    output logic             irq
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic             tx_full, rx_empty;
    logic [CNT_W-1:0] tx_cnt_nxt, rx_cnt_nxt, tx_free_nxt;
    logic             rx_en_nxt, tx_en_nxt;
    logic [ST_W-1:0]  set_vec;

    dmareq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(tx_wr_en), .push_data(tx_wr_data),
        .pop(tx_pop), .head_data(tx_pop_data),
        .full(tx_full), .empty(tx_empty), .count_nxt(tx_cnt_nxt)
    );

    dmareq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rx_rd_en), .head_data(rx_rd_data),
        .full(rx_full), .empty(rx_empty), .count_nxt(rx_cnt_nxt)
    );

    assign tx_free_nxt = CNT_W'(DEPTH) - tx_cnt_nxt;

    dmareq_req_fsm #(.CNT_W(CNT_W), .THRESH(THRESH)) rx_req_i (
        .clk(clk), .rst_n(rst_n), .en_nxt(rx_en_nxt), .level_nxt(rx_cnt_nxt),
        .req_single(rx_req_single), .req_burst(rx_req_burst)
    );

    dmareq_req_fsm #(.CNT_W(CNT_W), .THRESH(THRESH)) tx_req_i (
        .clk(clk), .rst_n(rst_n), .en_nxt(tx_en_nxt), .level_nxt(tx_free_nxt),
        .req_single(tx_req_single), .req_burst(tx_req_burst)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[ST_RX_DONE] = dma_rx_done;
        set_vec[ST_TX_DONE] = dma_tx_done;
        set_vec[ST_TX_OVF]  = tx_wr_en && tx_full;
        set_vec[ST_RX_UNF]  = rx_rd_en && rx_empty;
    end

    dmareq_ctl_regs ctl_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .set_vec(set_vec), .rx_en_nxt(rx_en_nxt), .tx_en_nxt(tx_en_nxt),
        .status(irq_status), .irq(irq)
    );
endmodule

// File: rtl/dmareq_chk.sv
module dmareq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_req_single,
    input logic       rx_req_burst,
    input logic       tx_req_single,
    input logic       tx_req_burst,
    input logic       tx_full,
    input logic       tx_empty,
    input logic       rx_empty,
    input logic       tx_wr_en,
    input logic       rx_rd_en,
    input logic       dma_rx_done,
    input logic       dma_tx_done,
    input logic [3:0] irq_status,
    input logic       irq
);
    // R2
    rx_single_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req_single |-> !rx_empty);
    // R3
    rx_burst_implies_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req_burst |-> rx_req_single);
    // R4
    tx_single_needs_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !tx_req_single);
    // R5
    tx_burst_implies_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_burst |-> tx_req_single);
    // R7
    tx_full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));
    // R8
    rx_done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_done |=> irq_status[0]);
    // R8
    tx_done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_done |=> irq_status[1]);
    // R9
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_status != 4'd0));
    // R10
    tx_overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_en && tx_full) |=> irq_status[2]);
    // R10
    rx_underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_en && rx_empty) |=> irq_status[3]);
endmodule

bind dmareq_gen dmareq_chk chk_i (
    .clk(clk), .rst_n(rst_n),
    .rx_req_single(rx_req_single), .rx_req_burst(rx_req_burst),
    .tx_req_single(tx_req_single), .tx_req_burst(tx_req_burst),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_empty(rx_empty),
    .tx_wr_en(tx_wr_en), .rx_rd_en(rx_rd_en),
    .dma_rx_done(dma_rx_done), .dma_tx_done(dma_tx_done),
    .irq_status(irq_status), .irq(irq)
);

// File: tb/dmareq_gen_tb.sv
`timescale 1ns/1ps
module dmareq_gen_tb_top;
    localparam int DEPTH = 8;
    localparam int THR   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [3:0]  reg_wdata = '0;
    logic        tx_wr_en = 1'b0;
    logic [15:0] tx_wr_data = '0;
    logic        tx_pop = 1'b0;
    logic [15:0] tx_pop_data;
    logic        tx_empty;
    logic        rx_push = 1'b0;
    logic [15:0] rx_push_data = '0;
    logic        rx_full;
    logic        rx_rd_en = 1'b0;
    logic [15:0] rx_rd_data;
    logic        dma_rx_done = 1'b0;
    logic        dma_tx_done = 1'b0;
    logic        rx_req_single, rx_req_burst, tx_req_single, tx_req_burst;
    logic [3:0]  irq_status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int tx_cnt = 0;
    int rx_cnt = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    dmareq_gen dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic check_reqs(input bit rx_en, input bit tx_en);
        int free = DEPTH - tx_cnt;
        check("R2 rx_single", int'(rx_req_single), int'(rx_en && rx_cnt >= 1));
        check("R3 rx_burst",  int'(rx_req_burst),  int'(rx_en && rx_cnt >= THR));
        check("R4 tx_single", int'(tx_req_single), int'(tx_en && free >= 1));
        check("R5 tx_burst",  int'(tx_req_burst),  int'(tx_en && free >= THR));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reqs", int'({rx_req_single, rx_req_burst, tx_req_single, tx_req_burst}), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 status", int'(irq_status), 0);
        check("R1 tx_empty", int'(tx_empty), 1);
        check("R1 rx_full", int'(rx_full), 0);

        // R6 enable both channels
        reg_write(2'd0, 4'b0011);
        check_reqs(1, 1);

        // R4 R5 R10 transmit fill sweep, one past full
        for (int i = 0; i <= DEPTH; i++) begin
            @(negedge clk); tx_wr_en = 1'b1; tx_wr_data = 16'(16'h1000 + i);
            @(negedge clk); tx_wr_en = 1'b0;
            if (tx_cnt < DEPTH) tx_cnt++;
            check_reqs(1, 1);
        end
        check("R10 tx overflow flag", int'(irq_status[2]), 1);
        check("R7 tx not empty", int'(tx_empty), 0);

        // R7 drain in order, requests tracked per pop
        for (int i = 0; i < DEPTH; i++) begin
            check("R7 tx order", int'(tx_pop_data), 16'h1000 + i);
            @(negedge clk); tx_pop = 1'b1;
            @(negedge clk); tx_pop = 1'b0;
            tx_cnt--;
            check_reqs(1, 1);
        end
        check("R7 tx empty", int'(tx_empty), 1);

        // R2 R3 R7 receive fill sweep, one past full (dropped)
        for (int i = 0; i <= DEPTH; i++) begin
            @(negedge clk); rx_push = 1'b1; rx_push_data = 16'(16'h2000 + 3 * i);
            @(negedge clk); rx_push = 1'b0;
            if (rx_cnt < DEPTH) rx_cnt++;
            check_reqs(1, 1);
        end
        check("R7 rx full", int'(rx_full), 1);
        for (int i = 0; i < DEPTH; i++) begin
            check("R7 rx order", int'(rx_rd_data), 16'h2000 + 3 * i);
            @(negedge clk); rx_rd_en = 1'b1;
            @(negedge clk); rx_rd_en = 1'b0;
            rx_cnt--;
            check_reqs(1, 1);
        end

        // R10 read from empty receive FIFO
        check("R10 unf before", int'(irq_status[3]), 0);
        @(negedge clk); rx_rd_en = 1'b1;
        @(negedge clk); rx_rd_en = 1'b0;
        check("R10 rx underflow flag", int'(irq_status[3]), 1);
        check_reqs(1, 1);
        @(negedge clk); rx_push = 1'b1; rx_push_data = 16'hBEEF;
        @(negedge clk); rx_push = 1'b0;
        rx_cnt = 1;
        check("R10 rx intact after unf", int'(rx_rd_data), 16'hBEEF);
        check_reqs(1, 1);

        // R6 enable gating and ignored address
        reg_write(2'd0, 4'b0010);
        check_reqs(0, 1);
        reg_write(2'd3, 4'b1111);
        check_reqs(0, 1);
        reg_write(2'd0, 4'b0001);
        check_reqs(1, 0);
        reg_write(2'd0, 4'b0011);
        check_reqs(1, 1);

        // R8 R9 status and interrupt
        reg_write(2'd2, 4'b1111);
        check("R8 clear all", int'(irq_status), 0);
        check("R9 irq idle", int'(irq), 0);
        @(negedge clk); dma_rx_done = 1'b1;
        @(negedge clk); dma_rx_done = 1'b0;
        check("R8 rx done set", int'(irq_status), 1);
        check("R9 masked", int'(irq), 0);
        repeat (2) @(negedge clk);
        check("R8 sticky", int'(irq_status), 1);
        reg_write(2'd1, 4'b0001);
        check("R9 unmasked", int'(irq), 1);
        reg_write(2'd2, 4'b0001);
        check("R8 w1c", int'(irq_status), 0);
        check("R9 irq after clear", int'(irq), 0);
        @(negedge clk); dma_tx_done = 1'b1; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 4'b0010;
        @(negedge clk); dma_tx_done = 1'b0; reg_we = 1'b0;
        check("R8 set wins", int'(irq_status), 2);
        check("R9 other mask", int'(irq), 0);
        reg_write(2'd1, 4'b0010);
        check("R9 tx mask", int'(irq), 1);
        // R9 error bit through mask
        @(negedge clk); rx_rd_en = 1'b1;
        @(negedge clk); rx_rd_en = 1'b0;
        rx_cnt = 0;
        @(negedge clk); rx_rd_en = 1'b1;
        @(negedge clk); rx_rd_en = 1'b0;
        reg_write(2'd2, 4'b0010);
        check("R10 unf again", int'(irq_status), 8);
        check("R9 unf masked", int'(irq), 0);
        reg_write(2'd1, 4'b1000);
        check("R9 unf unmasked", int'(irq), 1);
        check_reqs(1, 1);

        finish_run();
    end
endmodule